// File: doc/BRIEF.md
# Dual-Address I2C Port Slave

This block is the serial front end of a sixteen-pin port expander. It is a 7-bit I2C slave that answers to two addresses. The first address reaches a mixed group of eight pins: four inputs and four outputs. The second address reaches a group of eight outputs. SCL and SDA arrive raw from the pads, together with the four low address bits chosen by strapping decode elsewhere. The block drives an SDA pull-down and holds the output latches and the 4-bit interrupt mask. It also emits strobes to the separate transition-detect logic that owns the change flags and the interrupt pin.

The controller runs in the system clock. Its states are: `S_IDLE` (bus free), `S_ADDR` (receiving the address byte), `S_AACK` (acknowledging the address), `S_WDATA` (receiving a write byte), `S_WACK` (acknowledging a write byte), `S_RDATA` (shifting a read byte out), `S_RACK` (sampling the master's acknowledge) and `S_WAIT` (released, waiting for STOP or START). The transitions are as follows:
- START takes any state to `S_ADDR`.
- STOP takes any state to `S_IDLE`.
- From `S_ADDR`, the eighth falling SCL edge goes to `S_AACK` on an address hit, otherwise to `S_WAIT`.
- `S_AACK` goes to `S_RDATA` or `S_WDATA` according to the R/W bit.
- `S_WDATA` goes to `S_WACK` after eight bits, and `S_WACK` goes back to `S_WDATA`.
- `S_RDATA` goes to `S_RACK` after eight bits.
- `S_RACK` goes to `S_RDATA` on a master acknowledge, otherwise to `S_WAIT`.

Top module: `i2c_dual_port_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper three bits are 110 (mixed group) or 101 (output group) and its next four bits equal `addr_low`. It acknowledges that address and every byte written after it by pulling SDA low for the whole ninth clock. On any other address it neither acknowledges nor drives SDA until the next START.
- R2: Every data byte written to the mixed group loads `mix_out` = {bit7, bit6, bit1, bit0} and `irq_mask` = bits 5..2 of that byte.
- R3: Every data byte written to the output group loads all eight bits into `grp_b_out`.
- R4: A read of the mixed group returns two bytes in turn for as long as the master acknowledges. The first is `mix_pins` sampled at the preceding acknowledge. The second is {2'b00, `tflags`, 2'b00}, with `tflags` captured at the same acknowledge as that port byte.
- R5: `snap_stb` pulses for one clock at the address acknowledge of every mixed-group access and at each master acknowledge that precedes a port byte. It never pulses in an output-group access.
- R6: A read of the output group returns `grp_b_pins` resampled at every acknowledge.
- R7: After the master leaves a read byte unacknowledged, SDA stays released until STOP or START.
- R8: A repeated START in mid-transfer restarts address reception at once.
- R9: Taking `abort_n` low returns the interface to the idle state and leaves the outputs and the mask unchanged. Later bits are ignored until a new START.
- R10: `stop_stb` pulses once for every STOP on the bus.
- R11: After `rst_n`, `mix_out`, `irq_mask` and `grp_b_out` hold their parameter defaults (all ones) and SDA is released.
- R12: The SDA pull-down changes only while synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| abort_n | input | 1 | Asynchronous bus abort, active low |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level |
| sda_pull | output | 1 | 1 pulls SDA low |
| addr_low | input | 4 | Low four slave address bits |
| mix_pins | input | 8 | Pad levels of the mixed group, bit 7 down to 0: O7 O6 I5 I4 I3 I2 O1 O0 |
| grp_b_pins | input | 8 | Pad levels of the eight-output group |
| tflags | input | 4 | Change flags for I5..I2 from transition logic |
| mix_out | output | 4 | Mixed-group output latches {O7,O6,O1,O0} |
| grp_b_out | output | 8 | Eight-output group latches |
| irq_mask | output | 4 | Interrupt mask for I5..I2 |
| snap_stb | output | 1 | Input snapshot / flag clear strobe |
| stop_stb | output | 1 | STOP seen strobe |

## Verification
A wrong state shows up at the SDA pin within one SCL period. A lost or extra acknowledge flips the bit the master samples in the ninth clock. A mis-sequenced read phase swaps a port byte and a flag byte on the very next byte. A bit counter that is off by one skews every later read bit and moves the write commit, so the output latches take a shifted value at the end of that byte. A snapshot strobe in the wrong acknowledge changes the count of pulses seen per transaction, and a stale flag capture shows in the second byte of the following pair.

// File: rtl/i2cdp_pkg.sv
package i2cdp_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int PFX_W  = 3;
    localparam int LOW_W  = ADDR_W - PFX_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK,
        S_WAIT
    } xfer_st_t;
endpackage

// File: rtl/i2cdp_line_sync.sv
module i2cdp_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] delayed;

    assign raw = {sda_in, scl_in};

    for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe        <= '1;
                delayed[gi] <= 1'b1;
            end else begin
                pipe        <= {pipe[SYNC_STAGES-2:0], raw[gi]};
                delayed[gi] <= pipe[SYNC_STAGES-1];
            end
        end
        assign synced[gi] = pipe[SYNC_STAGES-1];
    end

    assign scl_s    = synced[0];
    assign sda_s    = synced[1];
    assign scl_rise = synced[0] & ~delayed[0];
    assign scl_fall = ~synced[0] & delayed[0];
    assign start_c  = synced[0] & delayed[0] & delayed[1] & ~synced[1];
    assign stop_c   = synced[0] & delayed[0] & ~delayed[1] & synced[1];
endmodule

// File: rtl/i2cdp_port_regs.sv
module i2cdp_port_regs #(
    parameter logic [3:0] MIX_OUT_RST = 4'hF,
    parameter logic [3:0] MASK_RST    = 4'hF,
    parameter logic [7:0] OUT8_RST    = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_mix,
    input  logic       wr_b,
    input  logic [7:0] wdata,
    output logic [3:0] mix_out,
    output logic [3:0] irq_mask,
    output logic [7:0] grp_b_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mix_out   <= MIX_OUT_RST;
            irq_mask  <= MASK_RST;
            grp_b_out <= OUT8_RST;
        end else begin
            if (wr_mix) begin
                mix_out  <= {wdata[7:6], wdata[1:0]};
                irq_mask <= wdata[5:2];
            end
            if (wr_b) begin
                grp_b_out <= wdata;
            end
        end
    end
endmodule

// File: rtl/i2cdp_tx_select.sv
module i2cdp_tx_select (
    input  logic       sel_b,
    input  logic       want_flag,
    input  logic [7:0] mix_pins,
    input  logic [7:0] grp_b_pins,
    input  logic [3:0] flag_hold,
    output logic [7:0] tx_byte
);
    always_comb begin
        if (sel_b) begin
            tx_byte = grp_b_pins;
        end else if (want_flag) begin
            tx_byte = {2'b00, flag_hold, 2'b00};
        end else begin
            tx_byte = mix_pins;
        end
    end
endmodule

// File: rtl/i2c_dual_port_slave.sv
module i2c_dual_port_slave
    import i2cdp_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] PFX_MIX     = 3'b110,
    parameter logic [2:0] PFX_OUT8    = 3'b101,
    parameter logic [3:0] MIX_OUT_RST = 4'hF,
    parameter logic [3:0] MASK_RST    = 4'hF,
    parameter logic [7:0] OUT8_RST    = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [3:0] addr_low,
    input  logic [7:0] mix_pins,
    input  logic [7:0] grp_b_pins,
    input  logic [3:0] tflags,
    output logic [3:0] mix_out,
    output logic [7:0] grp_b_out,
    output logic [3:0] irq_mask,
    output logic       snap_stb,
    output logic       stop_stb
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic fsm_rst_n;

    xfer_st_t         st, nxt;
    logic [BYTE_W-1:0] shreg, txreg, tx_byte;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw_q, grp_b_q, mack_q, flag_next_q;
    logic [3:0]        flag_hold;

    logic hit_a, hit_b, hit;
    logic addr_done, wr_stb, shift_in, rack_ld, tx_load;
    logic sel_b, want_flag, snap_now;

    assign fsm_rst_n = rst_n & abort_n;

    i2cdp_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    assign hit_a = (shreg[BYTE_W-1:1] == {PFX_MIX, addr_low});
    assign hit_b = (shreg[BYTE_W-1:1] == {PFX_OUT8, addr_low});
    assign hit   = hit_a | hit_b;

    assign shift_in  = scl_rise && (st == S_ADDR || st == S_WDATA);
    assign addr_done = (st == S_ADDR) && scl_fall && (bitcnt == FULL_CNT);
    assign wr_stb    = (st == S_WDATA) && scl_fall && (bitcnt == FULL_CNT);
    assign rack_ld   = (st == S_RACK) && scl_rise && !sda_s;
    assign tx_load   = (addr_done && hit && shreg[0]) || rack_ld;
    assign sel_b     = addr_done ? hit_b : grp_b_q;
    assign want_flag = addr_done ? 1'b0 : flag_next_q;
    assign snap_now  = (addr_done && hit_a) || (rack_ld && !grp_b_q && !flag_next_q);

    // state register
    always_ff @(posedge clk or negedge fsm_rst_n) begin
        if (!fsm_rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = st;
        if (start_c) begin
            nxt = S_ADDR;
        end else if (stop_c) begin
            nxt = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:  nxt = S_IDLE;
                S_ADDR:  if (addr_done) nxt = hit ? S_AACK : S_WAIT;
                S_AACK:  if (scl_fall) nxt = rw_q ? S_RDATA : S_WDATA;
                S_WDATA: if (wr_stb) nxt = S_WACK;
                S_WACK:  if (scl_fall) nxt = S_WDATA;
                S_RDATA: if (scl_fall && bitcnt == LAST_TX) nxt = S_RACK;
                S_RACK:  if (scl_fall) nxt = mack_q ? S_RDATA : S_WAIT;
                S_WAIT:  nxt = S_WAIT;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (st)
            S_AACK, S_WACK: sda_pull = 1'b1;
            S_RDATA:        sda_pull = ~txreg[BYTE_W-1];
            default:        sda_pull = 1'b0;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge fsm_rst_n) begin
        if (!fsm_rst_n) begin
            shreg       <= '0;
            txreg       <= '1;
            bitcnt      <= '0;
            rw_q        <= 1'b0;
            grp_b_q     <= 1'b0;
            mack_q      <= 1'b0;
            flag_next_q <= 1'b0;
            flag_hold   <= '0;
            snap_stb    <= 1'b0;
            stop_stb    <= 1'b0;
        end else begin
            snap_stb <= snap_now;
            stop_stb <= stop_c;

            if (start_c || st != nxt) begin
                bitcnt <= '0;
            end else if (shift_in || (st == S_RDATA && scl_fall)) begin
                bitcnt <= bitcnt + CNT_W'(1);
            end

            if (shift_in) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
            end

            if (addr_done) begin
                rw_q    <= shreg[0];
                grp_b_q <= hit_b;
            end

            if (st == S_RACK && scl_rise) begin
                mack_q <= !sda_s;
            end

            if (tx_load) begin
                txreg       <= tx_byte;
                flag_next_q <= sel_b ? 1'b0 : !want_flag;
                if (!sel_b && !want_flag) begin
                    flag_hold <= tflags;
                end
            end else if (st == S_RDATA && scl_fall) begin
                txreg <= {txreg[BYTE_W-2:0], 1'b1};
            end
        end
    end

    i2cdp_tx_select u_txsel (
        .sel_b      (sel_b),
        .want_flag  (want_flag),
        .mix_pins   (mix_pins),
        .grp_b_pins (grp_b_pins),
        .flag_hold  (flag_hold),
        .tx_byte    (tx_byte)
    );

    i2cdp_port_regs #(
        .MIX_OUT_RST (MIX_OUT_RST),
        .MASK_RST    (MASK_RST),
        .OUT8_RST    (OUT8_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mix    (wr_stb && !grp_b_q),
        .wr_b      (wr_stb && grp_b_q),
        .wdata     (shreg),
        .mix_out   (mix_out),
        .irq_mask  (irq_mask),
        .grp_b_out (grp_b_out)
    );
endmodule

// File: rtl/i2cdp_checker.sv
module i2cdp_checker
    import i2cdp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       abort_n,
    input xfer_st_t   st,
    input logic       sda_pull,
    input logic       scl_s,
    input logic       stop_c,
    input logic       snap_stb,
    input logic [7:0] grp_b_out,
    input logic [3:0] mix_out
);
    assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n || !abort_n)
        !$stable(sda_pull) |-> !scl_s);

    assert_out8_write_R3: assert property (@(posedge clk) disable iff (!rst_n || !abort_n)
        !$stable(grp_b_out) |-> $past(st) == S_WDATA);

    assert_mix_write_R2: assert property (@(posedge clk) disable iff (!rst_n || !abort_n)
        !$stable(mix_out) |-> $past(st) == S_WDATA);

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n || !abort_n)
        stop_c |=> st == S_IDLE);

    assert_snap_origin_R5: assert property (@(posedge clk) disable iff (!rst_n || !abort_n)
        snap_stb |-> ($past(st) == S_ADDR || $past(st) == S_RACK));
endmodule

bind i2c_dual_port_slave i2cdp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_n   (abort_n),
    .st        (st),
    .sda_pull  (sda_pull),
    .scl_s     (scl_s),
    .stop_c    (stop_c),
    .snap_stb  (snap_stb),
    .grp_b_out (grp_b_out),
    .mix_out   (mix_out)
);

// File: tb/i2c_dual_port_slave_test.sv
module i2c_dual_port_slave_test;
    localparam int Q = 10;
    localparam logic [3:0] MYLOW = 4'b0110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort_n = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic [3:0] addr_low = MYLOW;
    logic [7:0] mix_pins = 8'h00;
    logic [7:0] grp_b_pins = 8'h00;
    logic [3:0] tflags = 4'h0;
    logic sda_pull, snap_stb, stop_stb, sda_line;
    logic [3:0] mix_out, irq_mask;
    logic [7:0] grp_b_out;

    int n_chk = 0;
    int n_fail = 0;
    int snap_cnt = 0;
    int stop_cnt = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rd_got;
    event       rd_ev;

    always #2 clk = ~clk;
    assign sda_line = !(m_sda_low || sda_pull);

    i2c_dual_port_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_n    (abort_n),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .sda_pull   (sda_pull),
        .addr_low   (addr_low),
        .mix_pins   (mix_pins),
        .grp_b_pins (grp_b_pins),
        .tflags     (tflags),
        .mix_out    (mix_out),
        .grp_b_out  (grp_b_out),
        .irq_mask   (irq_mask),
        .snap_stb   (snap_stb),
        .stop_stb   (stop_stb)
    );

    always @(negedge clk) begin
        if (snap_stb) snap_cnt++;
        if (stop_stb) stop_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // monitor: pops the scoreboard for every byte read
    initial begin
        forever begin
            @(rd_ev);
            chk(rd_got == exp_q[0], tag_q[0], int'(rd_got), int'(exp_q[0]));
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda_low = 1'b0; wq();
    endtask

    task automatic clk_bit(input bit low, output bit s);
        m_sda_low = low; wq();
        m_scl = 1'b1; wq();
        s = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(!b[i], s);
        clk_bit(1'b0, s);
        ack = !s;
    endtask

    task automatic rd_byte(input bit mack, input logic [7:0] expv, input string tag);
        bit s;
        logic [7:0] b;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, s);
            b[i] = s;
        end
        clk_bit(mack, s);
        rd_got = b;
        ->rd_ev;
        @(negedge clk);
    endtask

    function automatic logic [7:0] adr(input logic [2:0] pfx, input bit rd);
        return {pfx, MYLOW, rd};
    endfunction

    initial begin
        bit ack;
        int snaps0, stops0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11 reset state
        chk(mix_out == 4'hF, "R11 mix_out", mix_out, 4'hF);
        chk(irq_mask == 4'hF, "R11 irq_mask", irq_mask, 4'hF);
        chk(grp_b_out == 8'hFF, "R11 grp_b_out", grp_b_out, 8'hFF);
        chk(sda_pull == 1'b0, "R11 sda released", sda_pull, 0);

        // R2 mixed writes, R1 acks, R10 stop strobe
        stops0 = stop_cnt;
        snaps0 = snap_cnt;
        bus_start();
        wr_byte(adr(3'b110, 1'b0), ack);
        chk(ack, "R1 mixed address ack", ack, 1);
        wr_byte(8'hA5, ack);
        chk(ack, "R1 data ack", ack, 1);
        chk(mix_out == 4'b1001, "R2 mix_out A5", mix_out, 4'b1001);
        chk(irq_mask == 4'b1001, "R2 mask A5", irq_mask, 4'b1001);
        wr_byte(8'h5A, ack);
        chk(mix_out == 4'b0110, "R2 mix_out 5A", mix_out, 4'b0110);
        chk(irq_mask == 4'b0110, "R2 mask 5A", irq_mask, 4'b0110);
        bus_stop();
        wq();
        chk(stop_cnt == stops0 + 1, "R10 stop strobe", stop_cnt - stops0, 1);
        chk(snap_cnt == snaps0 + 1, "R5 snap on mixed write", snap_cnt - snaps0, 1);

        // R3 output group writes
        snaps0 = snap_cnt;
        bus_start();
        wr_byte(adr(3'b101, 1'b0), ack);
        chk(ack, "R1 out8 address ack", ack, 1);
        wr_byte(8'h3C, ack);
        chk(grp_b_out == 8'h3C, "R3 first byte", grp_b_out, 8'h3C);
        wr_byte(8'hC3, ack);
        chk(grp_b_out == 8'hC3, "R3 second byte", grp_b_out, 8'hC3);
        bus_stop();
        chk(snap_cnt == snaps0, "R5 no snap for out8", snap_cnt - snaps0, 0);

        // R1 mismatched addresses
        addr_low = 4'b0111;
        bus_start();
        wr_byte(adr(3'b101, 1'b0), ack);
        chk(!ack, "R1 wrong low bits nack", ack, 0);
        wr_byte(8'h00, ack);
        chk(!ack, "R1 no data ack", ack, 0);
        bus_stop();
        addr_low = MYLOW;
        bus_start();
        wr_byte({3'b111, MYLOW, 1'b0}, ack);
        chk(!ack, "R1 wrong prefix nack", ack, 0);
        bus_stop();
        chk(grp_b_out == 8'hC3, "R1 out8 untouched", grp_b_out, 8'hC3);

        // R4 / R5 mixed read pairs
        mix_pins = 8'h96;
        tflags = 4'b0101;
        snaps0 = snap_cnt;
        bus_start();
        wr_byte(adr(3'b110, 1'b1), ack);
        chk(ack, "R1 mixed read ack", ack, 1);
        rd_byte(1'b1, 8'h96, "R4 port byte 1");
        mix_pins = 8'h3B;
        tflags = 4'b1010;
        rd_byte(1'b1, 8'h14, "R4 flag byte 1");
        rd_byte(1'b1, 8'h3B, "R4 port byte 2");
        rd_byte(1'b0, 8'h28, "R4 flag byte 2");
        bus_stop();
        chk(snap_cnt == snaps0 + 2, "R5 snaps in mixed read", snap_cnt - snaps0, 2);

        // R6 output group read, resampled every ack
        snaps0 = snap_cnt;
        grp_b_pins = 8'h81;
        bus_start();
        wr_byte(adr(3'b101, 1'b1), ack);
        grp_b_pins = 8'h7E;
        rd_byte(1'b1, 8'h81, "R6 byte 1");
        grp_b_pins = 8'h55;
        rd_byte(1'b1, 8'h7E, "R6 byte 2");
        rd_byte(1'b0, 8'h55, "R6 byte 3");
        bus_stop();
        chk(snap_cnt == snaps0, "R5 no snap in out8 read", snap_cnt - snaps0, 0);

        // R7 master nack releases SDA
        mix_pins = 8'h00;
        bus_start();
        wr_byte(adr(3'b110, 1'b1), ack);
        rd_byte(1'b0, 8'h00, "R7 last acked byte");
        rd_byte(1'b0, 8'hFF, "R7 released after nack");
        bus_stop();

        // R8 repeated start
        bus_start();
        wr_byte(adr(3'b110, 1'b0), ack);
        bus_start();
        wr_byte(adr(3'b101, 1'b0), ack);
        chk(ack, "R8 address after repeated start", ack, 1);
        wr_byte(8'h5A, ack);
        bus_stop();
        chk(grp_b_out == 8'h5A, "R8 out8 written", grp_b_out, 8'h5A);
        chk(mix_out == 4'b0110, "R8 mixed untouched", mix_out, 4'b0110);

        // R9 abort mid-byte
        bus_start();
        wr_byte(adr(3'b101, 1'b0), ack);
        begin
            bit s;
            for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
            abort_n = 1'b0;
            repeat (3) @(negedge clk);
            abort_n = 1'b1;
            for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
            clk_bit(1'b0, s);
            chk(s == 1'b1, "R9 no ack after abort", !s, 0);
        end
        chk(grp_b_out == 8'h5A, "R9 out8 unchanged", grp_b_out, 8'h5A);
        chk(irq_mask == 4'b0110, "R9 mask unchanged", irq_mask, 4'b0110);
        bus_stop();
        bus_start();
        wr_byte(adr(3'b101, 1'b0), ack);
        wr_byte(8'h11, ack);
        bus_stop();
        chk(grp_b_out == 8'h11, "R9 recovered", grp_b_out, 8'h11);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule